// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block owns the software-side control of four banks of sixteen general-purpose pins. For every bank it keeps a direction register, where a 1 makes the pin an output and a 0 leaves it an input, and an output value register. Both registers are written with a single 32-bit word. The upper half of the word is a per-bit mask and the lower half holds the new bit values. Software can therefore flip any subset of pins without first reading the register back.

A small override register holds one bit per bank. While a bank's bit is set, that bank's pad drive and pad enable come from internal debug vectors instead of the software registers. The software registers keep accepting writes during the override, and their contents reappear on the pins as soon as the override is cleared.

A read port returns the live input level of a bank's pins, one cycle after the read strobe. The pad drivers themselves sit outside the block.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first clock after it rises, every direction bit, every output bit, every override bit and `rd_data` are 0, whatever the debug inputs carry.
- R2: A write to a direction register sets the direction bits whose mask bit (`wr_data[31:16]`) is 1 to the matching bit of `wr_data[15:0]` and keeps all other bits. An all-zero mask changes nothing. The new value appears on `pad_oe` in the cycle after the strobe.
- R3: A write to an output value register follows the same masked rule and appears on `pad_out` in the cycle after the strobe. This also holds when a read is issued in the same cycle.
- R4: Direction registers are at addresses 5, 6, 7 and 8, and output value registers are at 9, 10, 11 and 12, for banks 0 to 3 in that order. Bank b occupies pad bits `[16*b+15:16*b]`, and a write to one bank leaves every other bank unchanged.
- R5: Bank b's `pad_oe` bits equal its direction register and its `pad_out` bits equal its output value register whenever its override bit is 0.
- R6: While override bit b is 1, bank b's `pad_out` and `pad_oe` follow `dbg_out` and `dbg_oe` for that bank, and the other banks are unaffected. Software writes to bank b still update its registers and take effect when the bit is cleared.
- R7: A write to address 14 loads override bits 3:0 from `wr_data[3:0]`, with bit b controlling bank b. `wr_data[31:4]` are ignored.
- R8: A write to any address other than 5 to 12 or 14 changes no register and no pad output.
- R9: When `rd_en` is high at a clock edge and `rd_addr` is 9 + b, `rd_data` becomes `{16'h0000, pad_in bank b}` after that edge. Any other `rd_addr` gives 0. `rd_data` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Write word: mask in 31:16, values in 15:0 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Registered read result |
| pad_in | input | 64 | Pin input levels, bank b in bits 16b+15:16b |
| pad_out | output | 64 | Pin drive values |
| pad_oe | output | 64 | Pin output enables, 1 = driven |
| dbg_out | input | 64 | Debug drive values used under override |
| dbg_oe | input | 64 | Debug output enables used under override |

## Verification
Two pairs of functions can act in the same cycle. The first pair is a masked software write landing on a bank whose override is active. The bench writes the output register of an overridden bank and checks that the pins stay on the debug vectors. It then clears the override and checks that the pins show the merged value that was written while they were hidden. The second pair is a value write and a pin read issued in the same clock to the same address. That cycle is judged by checking both the new `pad_out` slice and the `rd_data` word taken from `pad_in`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Register addresses that neighbouring software depends on.
  localparam int unsigned GPIO_DIR_BASE = 5;
  localparam int unsigned GPIO_VAL_BASE = 9;
  localparam int unsigned GPIO_OVR_ADDR = 14;

  // What kind of register an address selects.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DIR  = 2'd1,
    ACC_VAL  = 2'd2,
    ACC_OVR  = 2'd3
  } acc_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DIR_BASE  = GPIO_DIR_BASE,
  parameter int unsigned VAL_BASE  = GPIO_VAL_BASE,
  parameter int unsigned OVR_ADDR  = GPIO_OVR_ADDR,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [IDX_W-1:0]  bank
);

  always_comb begin
    kind = ACC_NONE;
    bank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(DIR_BASE + b)) begin
        kind = ACC_DIR;
        bank = IDX_W'(b);
      end
      if (addr == ADDR_W'(VAL_BASE + b)) begin
        kind = ACC_VAL;
        bank = IDX_W'(b);
      end
    end
    if (addr == ADDR_W'(OVR_ADDR)) begin
      kind = ACC_OVR;
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int unsigned BANK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_we,
  input  logic              val_we,
  input  logic [BANK_W-1:0] wmask,
  input  logic [BANK_W-1:0] wbits,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] val_q
);

  logic [BANK_W-1:0] dir_next;
  logic [BANK_W-1:0] val_next;

  // Masked merge: masked bits take the new value, others keep theirs.
  always_comb begin
    dir_next = (dir_q & ~wmask) | (wbits & wmask);
    val_next = (val_q & ~wmask) | (wbits & wmask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      val_q <= '0;
    end else begin
      if (dir_we) dir_q <= dir_next;
      if (val_we) val_q <= val_next;
    end
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned BANK_W = 16
) (
  input  logic              ovr_sel,
  input  logic [BANK_W-1:0] sw_out,
  input  logic [BANK_W-1:0] sw_oe,
  input  logic [BANK_W-1:0] ovr_out,
  input  logic [BANK_W-1:0] ovr_oe,
  output logic [BANK_W-1:0] pin_out,
  output logic [BANK_W-1:0] pin_oe
);

  always_comb begin
    if (ovr_sel) begin
      pin_out = ovr_out;
      pin_oe  = ovr_oe;
    end else begin
      pin_out = sw_out;
      pin_oe  = sw_oe;
    end
  end

endmodule

// File: rtl/gpio_read_port.sv
module gpio_read_port #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_hit,
  input  logic [IDX_W-1:0]  rd_bank,
  input  logic [PINS-1:0]   pad_in,
  output logic [2*BANK_W-1:0] rd_data
);

  logic [BANK_W-1:0] bank_lvl;

  always_comb begin
    bank_lvl = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_bank == IDX_W'(b)) bank_lvl = pad_in[b*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_hit ? {{BANK_W{1'b0}}, bank_lvl} : '0;
    end
  end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DIR_BASE  = GPIO_DIR_BASE,
  parameter int unsigned VAL_BASE  = GPIO_VAL_BASE,
  parameter int unsigned OVR_ADDR  = GPIO_OVR_ADDR,
  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W,
  localparam int unsigned DATA_W   = 2 * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic [PINS-1:0]   dbg_out,
  input  logic [PINS-1:0]   dbg_oe
);

  acc_kind_e             wkind;
  acc_kind_e             rkind;
  logic [IDX_W-1:0]      wbank;
  logic [IDX_W-1:0]      rbank;
  logic [NUM_BANKS-1:0]  ovr_en_q;
  logic [BANK_W-1:0]     wmask;
  logic [BANK_W-1:0]     wbits;
  logic [NUM_BANKS-1:0][BANK_W-1:0] sw_dir;
  logic [NUM_BANKS-1:0][BANK_W-1:0] sw_val;

  assign wmask = wr_data[DATA_W-1:BANK_W];
  assign wbits = wr_data[BANK_W-1:0];

  gpio_addr_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DIR_BASE  (DIR_BASE),
    .VAL_BASE  (VAL_BASE),
    .OVR_ADDR  (OVR_ADDR)
  ) u_wdec (
    .addr (wr_addr),
    .kind (wkind),
    .bank (wbank)
  );

  gpio_addr_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DIR_BASE  (DIR_BASE),
    .VAL_BASE  (VAL_BASE),
    .OVR_ADDR  (OVR_ADDR)
  ) u_rdec (
    .addr (rd_addr),
    .kind (rkind),
    .bank (rbank)
  );

  // Override enables: plain load of the low bits, no mask.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_en_q <= '0;
    end else if (wr_en && wkind == ACC_OVR) begin
      ovr_en_q <= wr_data[NUM_BANKS-1:0];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_sel;
    assign bank_sel = wr_en && (wbank == IDX_W'(b));

    gpio_bank_regs #(
      .BANK_W (BANK_W)
    ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_we (bank_sel && wkind == ACC_DIR),
      .val_we (bank_sel && wkind == ACC_VAL),
      .wmask  (wmask),
      .wbits  (wbits),
      .dir_q  (sw_dir[b]),
      .val_q  (sw_val[b])
    );

    gpio_pin_mux #(
      .BANK_W (BANK_W)
    ) u_mux (
      .ovr_sel (ovr_en_q[b]),
      .sw_out  (sw_val[b]),
      .sw_oe   (sw_dir[b]),
      .ovr_out (dbg_out[b*BANK_W +: BANK_W]),
      .ovr_oe  (dbg_oe[b*BANK_W +: BANK_W]),
      .pin_out (pad_out[b*BANK_W +: BANK_W]),
      .pin_oe  (pad_oe[b*BANK_W +: BANK_W])
    );
  end

  gpio_read_port #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_hit  (rkind == ACC_VAL),
    .rd_bank (rbank),
    .pad_in  (pad_in),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DIR_BASE  = 5,
  parameter int unsigned VAL_BASE  = 9,
  parameter int unsigned OVR_ADDR  = 14,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W,
  localparam int unsigned DATA_W   = 2 * BANK_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic [DATA_W-1:0]    rd_data,
  input logic [PINS-1:0]      pad_in,
  input logic [PINS-1:0]      pad_out,
  input logic [PINS-1:0]      pad_oe,
  input logic [PINS-1:0]      dbg_out,
  input logic [PINS-1:0]      dbg_oe,
  input logic [NUM_BANKS-1:0] ovr_en_q
);

  logic in_map;
  always_comb begin
    in_map = (wr_addr == ADDR_W'(OVR_ADDR));
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_addr == ADDR_W'(DIR_BASE + b)) in_map = 1'b1;
      if (wr_addr == ADDR_W'(VAL_BASE + b)) in_map = 1'b1;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && ovr_en_q == '0 && rd_data == '0));

  // R7
  ovr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(OVR_ADDR)) |=> (ovr_en_q == $past(wr_data[NUM_BANKS-1:0])));

  // R8
  ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_map && ovr_en_q == '0) |=> ($stable(pad_oe) && $stable(pad_out)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R2
    dir_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(DIR_BASE + b) && !ovr_en_q[b]) |=>
      (pad_oe[b*BANK_W +: BANK_W] ==
        (($past(pad_oe[b*BANK_W +: BANK_W]) & ~$past(wr_data[DATA_W-1:BANK_W])) |
         ($past(wr_data[BANK_W-1:0]) & $past(wr_data[DATA_W-1:BANK_W])))));

    // R3
    val_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(VAL_BASE + b) && !ovr_en_q[b]) |=>
      (pad_out[b*BANK_W +: BANK_W] ==
        (($past(pad_out[b*BANK_W +: BANK_W]) & ~$past(wr_data[DATA_W-1:BANK_W])) |
         ($past(wr_data[BANK_W-1:0]) & $past(wr_data[DATA_W-1:BANK_W])))));

    // R6
    override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_en_q[b] |-> (pad_out[b*BANK_W +: BANK_W] == dbg_out[b*BANK_W +: BANK_W] &&
                       pad_oe[b*BANK_W +: BANK_W]  == dbg_oe[b*BANK_W +: BANK_W]));

    // R9
    rd_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_addr == ADDR_W'(VAL_BASE + b)) |=>
      (rd_data == {{BANK_W{1'b0}}, $past(pad_in[b*BANK_W +: BANK_W])}));
  end

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_BANKS (NUM_BANKS),
  .BANK_W    (BANK_W),
  .ADDR_W    (ADDR_W),
  .DIR_BASE  (DIR_BASE),
  .VAL_BASE  (VAL_BASE),
  .OVR_ADDR  (OVR_ADDR)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .pad_in   (pad_in),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .dbg_out  (dbg_out),
  .dbg_oe   (dbg_oe),
  .ovr_en_q (ovr_en_q)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] pad_in = '0;
  logic [63:0] pad_out;
  logic [63:0] pad_oe;
  logic [63:0] dbg_out = 64'hAAAA_BBBB_CCCC_DDDD;
  logic [63:0] dbg_oe  = 64'h1234_5678_9ABC_DEF0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank_ctrl dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .dbg_out (dbg_out),
    .dbg_oe  (dbg_oe)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic [1:0]  bank;
    logic [15:0] exp_oe;
    logic [15:0] exp_out;
    logic [3:0]  req;
  } vec_t;

  // Each entry: one write, then the bank to inspect and its expected pins.
  localparam vec_t VEC [10] = '{
    '{8'd5,  32'hFFFF_A5A5, 2'd0, 16'hA5A5, 16'h0000, 4'd2}, // R2 full mask
    '{8'd5,  32'h00F0_0F0F, 2'd0, 16'hA505, 16'h0000, 4'd2}, // R2 partial mask
    '{8'd9,  32'h0FF0_1234, 2'd0, 16'hA505, 16'h0230, 4'd3}, // R3 partial mask
    '{8'd9,  32'h0000_FFFF, 2'd0, 16'hA505, 16'h0230, 4'd3}, // R3 empty mask
    '{8'd8,  32'hFFFF_BEEF, 2'd3, 16'hBEEF, 16'h0000, 4'd4}, // R4 bank 3 dir
    '{8'd12, 32'hF00F_C3C3, 2'd3, 16'hBEEF, 16'hC003, 4'd4}, // R4 bank 3 value
    '{8'd13, 32'hFFFF_FFFF, 2'd0, 16'hA505, 16'h0230, 4'd8}, // R8 hole in map
    '{8'd4,  32'hFFFF_FFFF, 2'd3, 16'hBEEF, 16'hC003, 4'd8}, // R8 below map
    '{8'd7,  32'h8001_FFFF, 2'd2, 16'h8001, 16'h0000, 4'd4}, // R4 bank 2 dir
    '{8'd10, 32'hFFFF_5555, 2'd1, 16'h0000, 16'h5555, 4'd5}  // R5 value without dir
  };

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] oe_of(input int b);
    return pad_oe[b*16 +: 16];
  endfunction

  function automatic logic [15:0] out_of(input int b);
    return pad_out[b*16 +: 16];
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, debug inputs nonzero
    check("R1", "pad_oe in reset", pad_oe, 64'h0);
    check("R1", "pad_out in reset", pad_out, 64'h0);
    check("R1", "rd_data in reset", {32'h0, rd_data}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pad_out after release", pad_out, 64'h0);

    for (int i = 0; i < 10; i++) begin
      do_write(VEC[i].addr, VEC[i].data);
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d oe", i),
            {48'h0, oe_of(int'(VEC[i].bank))}, {48'h0, VEC[i].exp_oe});
      check($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d out", i),
            {48'h0, out_of(int'(VEC[i].bank))}, {48'h0, VEC[i].exp_out});
    end
    // R4 whole bus after the table
    check("R4", "all pad_oe", pad_oe, 64'hBEEF_8001_0000_A505);
    check("R4", "all pad_out", pad_out, 64'hC003_0000_5555_0230);

    // R6 override bank 1 only
    do_write(8'd14, 32'h0000_0002);
    check("R6", "bank1 out override", {48'h0, out_of(1)}, 64'hCCCC);
    check("R6", "bank1 oe override", {48'h0, oe_of(1)}, 64'h9ABC);
    check("R6", "bank0 untouched", {32'h0, oe_of(0), out_of(0)}, 64'hA505_0230);
    // R6 write lands under override: pins stay on debug vectors
    do_write(8'd10, 32'hFFFF_0F0F);
    check("R6", "bank1 held under override", {48'h0, out_of(1)}, 64'hCCCC);
    // R7 upper bits ignored, low bits clear the override
    do_write(8'd14, 32'hFFFF_FFF0);
    check("R7", "bank1 out restored", {48'h0, out_of(1)}, 64'h0F0F);
    check("R7", "bank1 oe restored", {48'h0, oe_of(1)}, 64'h0000);
    do_write(8'd14, 32'h0000_0010);
    check("R7", "bit 4 ignored", pad_out, 64'hC003_0000_0F0F_0230);
    do_write(8'd14, 32'h0000_000F);
    check("R6", "all banks override out", pad_out, dbg_out);
    check("R6", "all banks override oe", pad_oe, dbg_oe);
    do_write(8'd14, 32'h0000_0000);
    check("R5", "software drive back", pad_oe, 64'hBEEF_8001_0000_A505);

    // R9 reads
    pad_in = 64'h1111_2222_3333_4444;
    do_read(8'd9);
    check("R9", "read bank0", {32'h0, rd_data}, 64'h0000_4444);
    do_read(8'd12);
    check("R9", "read bank3", {32'h0, rd_data}, 64'h0000_1111);
    @(negedge clk);
    check("R9", "rd_data held", {32'h0, rd_data}, 64'h0000_1111);
    do_read(8'd5);
    check("R9", "read dir address", {32'h0, rd_data}, 64'h0);

    // R3 write and read in the same cycle on bank 2
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'd11; wr_data = 32'hFFFF_7777;
    rd_en = 1'b1; rd_addr = 8'd11;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R3", "bank2 out with read", {48'h0, out_of(2)}, 64'h7777);
    check("R9", "bank2 read with write", {32'h0, rd_data}, 64'h0000_2222);

    // R1 reset in mid run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pad_oe after rerun reset", pad_oe, 64'h0);
    check("R1", "pad_out after rerun reset", pad_out, 64'h0);
    check("R1", "rd_data after rerun reset", {32'h0, rd_data}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule